// File: doc/BRIEF.md
# Serial Configuration Port with Nonvolatile Power-Up Load

This block holds a small bank of 28-bit configuration words that select output formats and clock sources elsewhere on the chip. A host changes them over a four-wire serial port with a latch-enable line (`spi_le`). The host pulls the line low, clocks in a 32-bit frame on `spi_clk`, and raises the line again to commit the frame. Read data leaves on `miso_d`. The output is enabled only while the latch enable is low, so the pin can share a board-level bus.

Power-up defaults come from a nonvolatile shadow store, modelled here as a fixed table computed from a seed parameter. When the active-low `pwr_n` input rises, a sequencer copies the shadow table into the working registers, one word per clock. It does so only if the latch enable was already high before that edge. Writes that arrive while a copy is starting or in progress are parked and applied after the copy, so the host's value wins. All serial pins are oversampled by the system clock `clk`.

Top module: `cfg_spi_loader`

## Requirements
- R1: After reset every configuration word reads 0 and `load_done` is 0.
- R2: `miso_en` is 1 exactly while `spi_le` is 0.
- R3: A `pwr_n` rising edge, with `spi_le` high in the clk sample before the edge is seen, copies shadow entry i into register i for every i. Shadow entry i is SHADOW_SEED XOR (i × 0x0111111), kept to 28 bits.
- R4: A `pwr_n` rising edge while `spi_le` is low, or in the same clk sample as the `spi_le` rise, leaves every register unchanged.
- R5: Take `pwr_n` rising between two clk edges as the start. `load_done` then reads 0 after NUM_REGS+1 clk rising edges and 1 after NUM_REGS+2. It holds that value until the next load starts.
- R6: A frame is 32 bits, MSB first, each bit taken at a `spi_clk` rising edge while `spi_le` is low. Bits [3:0] give the address and bits [31:4] the data. The `spi_le` rise writes the data into the addressed register.
- R7: A frame with any bit count other than 32 (for example 31 or 33) writes nothing.
- R8: A write to an address from NUM_REGS to 14 is ignored.
- R9: Address 15 is a read command whose bits [7:4] give an index. During the next frame, `miso_d` carries {register data, index}, 32 bits MSB first. The first bit is valid once `spi_le` falls, and each later bit follows a `spi_clk` falling edge. An index of NUM_REGS or more returns data 0.
- R10: A write committed while a load is starting or running takes effect after the load, overriding the shadow value.
- R11: A read-command frame changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_clk | input | 1 | Serial clock; idles high |
| spi_le | input | 1 | Latch enable; low frames a transfer, rising edge commits |
| spi_mosi | input | 1 | Serial data in |
| pwr_n | input | 1 | Active-low power-down; rising edge requests the shadow load |
| miso_d | output | 1 | Serial data out |
| miso_en | output | 1 | Output enable for the three-state MISO pad driver |
| load_done | output | 1 | High once a shadow copy has completed |
| cfg_o | output | NUM_REGS*28 | Configuration words; register i at bits [i*28 +: 28] |

## Verification
The bench builds the block with NUM_REGS = 6 and a non-default shadow seed. Addresses 6 to 14 then fall outside the bank, which brings the ignored-write rule and the zero-data read-back within reach. The seed makes every shadow word differ from both the reset value and the values the host writes. The bench sets the `spi_le` and `pwr_n` edges to coincide or to sit one cycle apart. This covers the same-edge rule for the load gate and the deferred write that has to win over a copy in progress.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = FRAME_W - ADDR_W;
  localparam logic [ADDR_W-1:0] RD_CODE = 4'hF;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
  } frame_t;
endpackage

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
  import cfg_spi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   spi_clk,
  input  logic   spi_le,
  input  logic   spi_mosi,
  input  frame_t tx_word,
  output logic   le_prev,
  output logic   le_fall,
  output logic   cmt_v,
  output frame_t cmt_frame,
  output logic   miso_d
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclk_r, sclk_rr, le_r, le_rr, mosi_r;
  logic [FRAME_W-1:0] rx_q, rx_n, tx_q, tx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic cmt_n;
  frame_t cmt_frame_n;
  logic sclk_rise, sclk_fall, le_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r  <= 1'b1;
      sclk_rr <= 1'b1;
      le_r    <= 1'b1;
      le_rr   <= 1'b1;
      mosi_r  <= 1'b1;
    end else begin
      sclk_r  <= spi_clk;
      sclk_rr <= sclk_r;
      le_r    <= spi_le;
      le_rr   <= le_r;
      mosi_r  <= spi_mosi;
    end
  end

  assign sclk_rise = sclk_r & ~sclk_rr;
  assign sclk_fall = ~sclk_r & sclk_rr;
  assign le_rise   = le_r & ~le_rr;
  assign le_fall   = ~le_r & le_rr;
  assign le_prev   = le_rr;
  assign miso_d    = tx_q[FRAME_W-1];

  always_comb begin
    rx_n        = rx_q;
    tx_n        = tx_q;
    cnt_n       = cnt_q;
    cmt_frame_n = cmt_frame;
    cmt_n       = le_rise && (cnt_q == CNT_FULL);
    if (le_rise) cmt_frame_n = frame_t'(rx_q);
    if (le_fall) begin
      cnt_n = '0;
      tx_n  = FRAME_W'(tx_word);
    end else if (!le_r) begin
      if (sclk_rise) begin
        rx_n = {rx_q[FRAME_W-2:0], mosi_r};
        if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
      end
      if (sclk_fall && cnt_q != '0) tx_n = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      cmt_v     <= 1'b0;
      cmt_frame <= '0;
    end else begin
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      cnt_q     <= cnt_n;
      cmt_v     <= cmt_n;
      cmt_frame <= cmt_frame_n;
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_r && le_rr) |=> $stable(tx_q));
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             le_prev,
  output logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  logic pd_r, pd_rr;
  logic busy_n, done_n;
  logic [IDX_W-1:0] idx_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_r  <= 1'b0;
      pd_rr <= 1'b0;
    end else begin
      pd_r  <= pwr_n;
      pd_rr <= pd_r;
    end
  end

  assign start = pd_r & ~pd_rr & le_prev;

  always_comb begin
    busy_n = busy;
    idx_n  = idx;
    done_n = done;
    if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
      done_n = 1'b0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_n;
      idx  <= idx_n;
      done <= done_n;
    end
  end

  // R5
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R3
  start_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && idx == '0));
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= LAST));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_spi_pkg::*;
#(
  parameter int                NUM_REGS    = 8,
  parameter int                IDX_W       = 3,
  parameter logic [DATA_W-1:0] SHADOW_SEED = 28'h3B1E7D2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmt_v,
  input  frame_t                     cmt_frame,
  input  logic                       le_fall,
  input  logic                       start,
  input  logic                       busy,
  input  logic [IDX_W-1:0]           idx,
  output frame_t                     tx_word,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(NUM_REGS);

  function automatic logic [DATA_W-1:0] shadow_word(input int i);
    return SHADOW_SEED ^ (DATA_W'(i) * 28'h0111111);
  endfunction

  logic new_wr, new_rd, hold;
  logic pend_v, pend_v_n;
  logic [ADDR_W-1:0] pend_addr, pend_addr_n, rd_idx, rd_idx_n;
  logic [DATA_W-1:0] pend_data, pend_data_n;
  logic rd_pend, rd_pend_n;
  logic [DATA_W-1:0] rd_arr [NUM_REGS];

  assign new_rd = cmt_v && (cmt_frame.addr == RD_CODE);
  assign new_wr = cmt_v && (cmt_frame.addr != RD_CODE) && (cmt_frame.addr < LIM);
  assign hold   = busy | start;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
      logic [DATA_W-1:0] q, nxt;
      logic en;
      always_comb begin
        nxt = q;
        en  = 1'b0;
        if (busy && idx == IDX_W'(g)) begin
          nxt = shadow_word(g);
          en  = 1'b1;
        end
        if (!hold) begin
          if (pend_v && pend_addr == ADDR_W'(g)) begin
            nxt = pend_data;
            en  = 1'b1;
          end
          if (new_wr && cmt_frame.addr == ADDR_W'(g)) begin
            nxt = cmt_frame.data;
            en  = 1'b1;
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= nxt;
      end
      assign cfg_o[g*DATA_W +: DATA_W] = q;
      assign rd_arr[g] = q;
    end
  endgenerate

  always_comb begin
    pend_v_n    = pend_v;
    pend_addr_n = pend_addr;
    pend_data_n = pend_data;
    if (hold) begin
      if (new_wr) begin
        pend_v_n    = 1'b1;
        pend_addr_n = cmt_frame.addr;
        pend_data_n = cmt_frame.data;
      end
    end else begin
      pend_v_n = 1'b0;
    end
    rd_pend_n = rd_pend;
    rd_idx_n  = rd_idx;
    if (le_fall) begin
      rd_pend_n = 1'b0;
    end else if (new_rd) begin
      rd_pend_n = 1'b1;
      rd_idx_n  = cmt_frame.data[ADDR_W-1:0];
    end
  end

  always_comb begin
    tx_word = '0;
    if (rd_pend) begin
      tx_word.addr = rd_idx;
      for (int k = 0; k < NUM_REGS; k++)
        if (rd_idx == ADDR_W'(k)) tx_word.data = rd_arr[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      rd_pend   <= 1'b0;
      rd_idx    <= '0;
    end else begin
      pend_v    <= pend_v_n;
      pend_addr <= pend_addr_n;
      pend_data <= pend_data_n;
      rd_pend   <= rd_pend_n;
      rd_idx    <= rd_idx_n;
    end
  end

  // R10
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !hold) |=> !pend_v);
endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfg_spi_pkg::*;
#(
  parameter int                NUM_REGS    = 8,
  parameter logic [DATA_W-1:0] SHADOW_SEED = 28'h3B1E7D2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_clk,
  input  logic                       spi_le,
  input  logic                       spi_mosi,
  input  logic                       pwr_n,
  output logic                       miso_d,
  output logic                       miso_en,
  output logic                       load_done,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [1:0] rst_sync;
  logic rst_s_n;
  logic le_prev, le_fall, cmt_v, start, busy;
  frame_t cmt_frame, tx_word;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign miso_en = ~spi_le;

  cfg_spi_port u_port (
    .clk(clk), .rst_n(rst_s_n), .spi_clk(spi_clk), .spi_le(spi_le),
    .spi_mosi(spi_mosi), .tx_word(tx_word), .le_prev(le_prev),
    .le_fall(le_fall), .cmt_v(cmt_v), .cmt_frame(cmt_frame), .miso_d(miso_d)
  );

  cfg_load_seq #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .pwr_n(pwr_n), .le_prev(le_prev),
    .start(start), .busy(busy), .idx(idx), .done(load_done)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SHADOW_SEED(SHADOW_SEED)) u_bank (
    .clk(clk), .rst_n(rst_s_n), .cmt_v(cmt_v), .cmt_frame(cmt_frame),
    .le_fall(le_fall), .start(start), .busy(busy), .idx(idx),
    .tx_word(tx_word), .cfg_o(cfg_o)
  );
endmodule

// File: tb/cfg_spi_loader_tb.sv
`timescale 1ns/1ps
module cfg_spi_loader_tb;
  localparam int N = 6;
  localparam logic [27:0] SEED = 28'h5A3C96F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_clk = 1'b1, spi_le = 1'b1, spi_mosi = 1'b1, pwr_n = 1'b0;
  logic miso_d, miso_en, load_done;
  logic [N*28-1:0] cfg;

  int checks = 0, errors = 0, cd = 0;
  logic done_exp = 1'b0;
  bit mon_on = 0, finished = 0;
  logic [27:0] exp_r [N];
  logic [31:0] rd;

  cfg_spi_loader #(.NUM_REGS(N), .SHADOW_SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_le(spi_le),
    .spi_mosi(spi_mosi), .pwr_n(pwr_n), .miso_d(miso_d), .miso_en(miso_en),
    .load_done(load_done), .cfg_o(cfg)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] shadow_exp(int i);
    return SEED ^ (28'(i) * 28'h0111111);
  endfunction

  // reference model of load_done (R5)
  always @(posedge clk) begin
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == N) done_exp = 1'b0;
      if (cd == 0) done_exp = 1'b1;
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (mon_on && !finished) begin
      chk("R2 miso_en", {31'b0, miso_en}, {31'b0, ~spi_le});
      chk("R5 load_done", {31'b0, load_done}, {31'b0, done_exp});
    end
  end

  task automatic check_regs(string req);
    for (int i = 0; i < N; i++) chk(req, {4'b0, cfg[i*28 +: 28]}, {4'b0, exp_r[i]});
  endtask

  task automatic frame(input logic [31:0] w, input int nbits, input bit load_after,
                       output logic [31:0] got);
    got = '0;
    @(negedge clk) spi_le = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_clk  = 1'b0;
      spi_mosi = (i < 32) ? w[31 - i] : 1'b0;
      repeat (3) @(negedge clk);
      if (i < 32) got[31 - i] = miso_d;
      spi_clk = 1'b1;
      repeat (3) @(negedge clk);
    end
    spi_le = 1'b1;
    if (load_after) begin
      @(negedge clk);
      pwr_n = 1'b1;
      cd = N + 2;
    end
    repeat (N + 6) @(negedge clk);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [27:0] d);
    logic [31:0] dummy;
    frame({d, a}, 32, 1'b0, dummy);
    if (a < 4'(N)) exp_r[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;

    // R1 reset state
    for (int i = 0; i < N; i++) exp_r[i] = '0;
    check_regs("R1 reset regs");
    chk("R1 reset done", {31'b0, load_done}, 32'd0);

    // R3 power-up load with latch enable high; R5 exact timing
    pwr_n = 1'b1;
    cd = N + 2;
    repeat (N + 1) @(negedge clk);
    chk("R5 done not yet", {31'b0, load_done}, 32'd0);
    @(negedge clk);
    chk("R5 done set", {31'b0, load_done}, 32'd1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) exp_r[i] = shadow_exp(i);
    check_regs("R3 shadow copy");

    // R6 writes, including first and last register
    write_reg(4'd2, 28'hABCDEF1);
    write_reg(4'd0, 28'h0000001);
    write_reg(4'(N - 1), 28'hFFFFFFF);
    check_regs("R6 writes");

    // R7 short and long frames
    frame({28'h1234567, 4'd1}, 31, 1'b0, rd);
    frame({28'h7654321, 4'd1}, 33, 1'b0, rd);
    check_regs("R7 bad length");

    // R8 out-of-range addresses
    write_reg(4'(N), 28'h1111111);
    write_reg(4'd14, 28'h2222222);
    check_regs("R8 out of range");

    // R9 read-back; R11 reads change nothing
    frame({24'h0, 4'd2, 4'hF}, 32, 1'b0, rd);
    frame({24'h0, 4'd9, 4'hF}, 32, 1'b0, rd);
    chk("R9 read reg2", rd, {exp_r[2], 4'd2});
    frame({24'h0, 4'(N - 1), 4'hF}, 32, 1'b0, rd);
    chk("R9 read idx9 out of range", rd, {28'h0, 4'd9});
    frame({24'h0, 4'd0, 4'hF}, 32, 1'b0, rd);
    chk("R9 read last reg", rd, {exp_r[N-1], 4'(N - 1)});
    frame({28'h0000003, 4'd4}, 32, 1'b0, rd);
    exp_r[4] = 28'h0000003;
    chk("R9 read reg0", rd, {exp_r[0], 4'd0});
    check_regs("R11 read commands");

    // R4 power-down release while latch enable low
    @(negedge clk) pwr_n = 1'b0;
    repeat (3) @(negedge clk);
    spi_le = 1'b0;
    repeat (3) @(negedge clk);
    pwr_n = 1'b1;
    repeat (N + 4) @(negedge clk);
    spi_le = 1'b1;
    repeat (4) @(negedge clk);
    check_regs("R4 le low");

    // R4 latch enable and power-down released on the same edge
    pwr_n = 1'b0;
    spi_le = 1'b0;
    repeat (3) @(negedge clk);
    spi_le = 1'b1;
    pwr_n = 1'b1;
    repeat (N + 4) @(negedge clk);
    check_regs("R4 same edge");

    // R10 write committed as a load starts is applied after it
    pwr_n = 1'b0;
    repeat (3) @(negedge clk);
    frame({28'h0C0FFEE, 4'd3}, 32, 1'b1, rd);
    for (int i = 0; i < N; i++) exp_r[i] = shadow_exp(i);
    exp_r[3] = 28'h0C0FFEE;
    check_regs("R10 deferred write");
    chk("R10 load completed", {31'b0, load_done}, 32'd1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule